// File: doc/BRIEF.md
# Signed/Unsigned Integer ALU

This block is a purely combinational integer arithmetic-logic unit for a processor datapath. It takes two operands of `WIDTH` bits (32 by default), a 4-bit function selector and a single mode bit. From these it drives a result word and a 4-bit condition code. Six functions are implemented: addition, subtraction, bitwise AND, bitwise OR, set-on-less-than and multiplication. There is one function code for each. The mode bit decides whether the operands are read as two's-complement or as plain binary magnitudes. Every other function code gives a zero word.

The condition code shows whether the selected arithmetic function could not represent its true result in `WIDTH` bits. For add and subtract, the wrapped low word is still presented on the result. The block has no clock and no state. Any change on any input reaches the outputs within the same evaluation.

Top module: `alu32_core`

## Requirements
- R1: Function code 4'h0 (add) outputs `a + b` modulo 2^WIDTH, in both modes.
- R2: Function code 4'h1 (subtract) outputs `a - b` modulo 2^WIDTH, in both modes.
- R3: With `is_signed`=1, add and subtract report condition code 4'b0001 when the two's-complement result overflows or underflows. Otherwise they report 4'b0000.
- R4: With `is_signed`=0, add reports 4'b0001 on a carry out of the top bit. Subtract reports 4'b0001 when `a < b`, that is, on a borrow. Otherwise the code is 4'b0000.
- R5: Function codes 4'h2 (AND) and 4'h3 (OR) output the bitwise result and condition code 4'b0000. The `is_signed` bit has no effect on either output.
- R6: Function code 4'hB outputs 1 when `a < b` and 0 otherwise. The comparison is signed when `is_signed`=1 and unsigned when it is 0. The condition code is always 4'b0000, even when the operand difference overflows.
- R7: Function code 4'hE (multiply) outputs the low WIDTH bits of the full product, with the operands sign- or zero-extended according to `is_signed`.
- R8: Multiply reports 4'b0001 when the full product does not fit in WIDTH bits. In signed mode, that means the top WIDTH+1 product bits are not all equal. In unsigned mode, it means the top WIDTH bits are not zero.
- R9: Function codes 4'h4 to 4'hA, 4'hC, 4'hD and 4'hF output a zero result and condition code 4'b0000 for any operands and mode.
- R10: The outputs follow any change on `a`, `b`, `fn` or `is_signed` with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| fn | input | 4 | Function selector |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| result | output | WIDTH | Function result |
| cond | output | 4 | Condition code: 0000 no error, 0001 overflow/underflow |

## Verification
Set-on-less-than and subtraction can be triggered by the same operands in the same evaluation, because the comparison must hold even when the operand difference overflows. The bench provokes this with signed operands at opposite extremes, such as the most negative value against the most positive value. It then checks that the compare result is correct and that the condition code stays at 0000. The same operand pair under subtract must raise 0001. Inside the RTL, the compare output is also checked against the subtractor's sign and overflow for every set-on-less-than evaluation.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
   localparam int FN_W  = 4;
   localparam int CC_W  = 4;

   localparam logic [FN_W-1:0] FN_ADD = 4'h0;
   localparam logic [FN_W-1:0] FN_SUB = 4'h1;
   localparam logic [FN_W-1:0] FN_AND = 4'h2;
   localparam logic [FN_W-1:0] FN_OR  = 4'h3;
   localparam logic [FN_W-1:0] FN_SLT = 4'hB;
   localparam logic [FN_W-1:0] FN_MUL = 4'hE;

   localparam logic [CC_W-1:0] CC_OK  = 4'b0000;
   localparam logic [CC_W-1:0] CC_OVF = 4'b0001;
endpackage

// File: rtl/alu32_addsub.sv
module alu32_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             do_sub,
   input  logic             is_signed,
   output logic [WIDTH-1:0] sum,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu32_addsub: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   wide;
   logic             carry;
   logic             sgn_ovf;

   always_comb begin
      b_eff   = do_sub ? ~b : b;
      wide    = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, do_sub};
      sum     = wide[WIDTH-1:0];
      carry   = wide[WIDTH];
      sgn_ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
      if (is_signed) ovf = sgn_ovf;
      else           ovf = do_sub ? ~carry : carry;
   end

   // R4: an unsigned add without carry never yields a value below operand a
   always_comb begin
      if (!do_sub && !is_signed && !ovf)
         p_nowrap_r4: assert (sum >= a) else $error("unsigned add wrapped without flag");
      if (do_sub && !is_signed && !ovf)
         p_noborrow_r4: assert (a >= b) else $error("unsigned sub borrowed without flag");
   end
endmodule

// File: rtl/alu32_mul.sv
module alu32_mul #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             is_signed,
   output logic [WIDTH-1:0] prod_lo,
   output logic             ovf
);
   localparam int PW = 2 * WIDTH;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu32_mul: WIDTH must be at least 2");
   end

   logic [PW-1:0]  ext_a;
   logic [PW-1:0]  ext_b;
   logic [PW-1:0]  prod;
   logic [WIDTH:0] top_s;

   always_comb begin
      ext_a   = is_signed ? {{WIDTH{a[WIDTH-1]}}, a} : {{WIDTH{1'b0}}, a};
      ext_b   = is_signed ? {{WIDTH{b[WIDTH-1]}}, b} : {{WIDTH{1'b0}}, b};
      prod    = ext_a * ext_b;
      prod_lo = prod[WIDTH-1:0];
      top_s   = prod[PW-1:WIDTH-1];
      if (is_signed) ovf = (top_s != '0) && (top_s != '1);
      else           ovf = (prod[PW-1:WIDTH] != '0);
   end
endmodule

// File: rtl/alu32_logic.sv
module alu32_logic #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             is_signed,
   output logic [WIDTH-1:0] and_o,
   output logic [WIDTH-1:0] or_o,
   output logic             lt_o
);
   always_comb begin
      and_o = a & b;
      or_o  = a | b;
      lt_o  = is_signed ? ($signed(a) < $signed(b)) : (a < b);
   end
endmodule

// File: rtl/alu32_core.sv
module alu32_core
   import alu32_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [3:0]       fn,
   input  logic             is_signed,
   output logic [WIDTH-1:0] result,
   output logic [3:0]       cond
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu32_core: WIDTH must be at least 2");
   end
   if (FN_W != 4 || CC_W != 4) begin : g_bad_codes
      $error("alu32_core: function and condition fields must be 4 bits");
   end

   logic [WIDTH-1:0] as_sum;
   logic             as_ovf;
   logic             as_sub;
   logic [WIDTH-1:0] m_lo;
   logic             m_ovf;
   logic [WIDTH-1:0] l_and;
   logic [WIDTH-1:0] l_or;
   logic             l_lt;

   assign as_sub = (fn != FN_ADD);

   alu32_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a(a), .b(b), .do_sub(as_sub), .is_signed(is_signed),
      .sum(as_sum), .ovf(as_ovf)
   );

   alu32_mul #(.WIDTH(WIDTH)) u_mul (
      .a(a), .b(b), .is_signed(is_signed),
      .prod_lo(m_lo), .ovf(m_ovf)
   );

   alu32_logic #(.WIDTH(WIDTH)) u_logic (
      .a(a), .b(b), .is_signed(is_signed),
      .and_o(l_and), .or_o(l_or), .lt_o(l_lt)
   );

   always_comb begin
      result = '0;
      cond   = CC_OK;
      case (fn)
         FN_ADD, FN_SUB: begin
            result = as_sum;
            cond   = as_ovf ? CC_OVF : CC_OK;
         end
         FN_AND: result = l_and;
         FN_OR:  result = l_or;
         FN_SLT: result = {{(WIDTH-1){1'b0}}, l_lt};
         FN_MUL: begin
            result = m_lo;
            cond   = m_ovf ? CC_OVF : CC_OK;
         end
         default: ;
      endcase
   end

   // Cross-checks between the comparator, subtractor and multiplier
   always_comb begin
      if (fn == FN_SLT && is_signed)
         p_slt_vs_sub_s_r6: assert (l_lt == (as_sum[MSB] ^ as_ovf))
            else $error("signed compare disagrees with subtractor");
      if (fn == FN_SLT && !is_signed)
         p_slt_vs_sub_u_r6: assert (l_lt == as_ovf)
            else $error("unsigned compare disagrees with borrow");
      if (fn == FN_SLT)
         p_slt_nocc_r6: assert (cond == CC_OK && result[WIDTH-1:1] == '0)
            else $error("compare drove a flag or upper bits");
      if (fn == FN_MUL && !is_signed && cond == CC_OK && b != '0)
         p_mul_exact_r8: assert ((result / b) == a && (result % b) == '0)
            else $error("unflagged unsigned product is not exact");
      if (fn == FN_AND || fn == FN_OR)
         p_logic_nocc_r5: assert (cond == CC_OK)
            else $error("logic op raised a flag");
      if (!(fn inside {FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT, FN_MUL}))
         p_unused_zero_r9: assert (result == '0 && cond == CC_OK)
            else $error("unused code drove nonzero output");
   end
endmodule

// File: tb/alu32_core_bench.sv
module alu32_core_bench;
   typedef struct packed {
      logic [3:0]  fn;
      logic        sg;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] r;
      logic [3:0]  cc;
      logic [23:0] tag;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t VEC [NV] = '{
      '{4'h0, 1'b1, 32'h00000005, 32'h00000007, 32'h0000000C, 4'b0000, "R1 "},
      '{4'h0, 1'b0, 32'h12345678, 32'h11111111, 32'h23456789, 4'b0000, "R1 "},
      '{4'h0, 1'b1, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 4'b0001, "R3 "},
      '{4'h0, 1'b1, 32'h80000000, 32'hFFFFFFFF, 32'h7FFFFFFF, 4'b0001, "R3 "},
      '{4'h0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'b0001, "R4 "},
      '{4'h0, 1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 4'b0000, "R4 "},
      '{4'h1, 1'b1, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 4'b0000, "R2 "},
      '{4'h1, 1'b0, 32'h00000005, 32'h00000003, 32'h00000002, 4'b0000, "R2 "},
      '{4'h1, 1'b1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 4'b0001, "R3 "},
      '{4'h1, 1'b1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 4'b0001, "R3 "},
      '{4'h1, 1'b0, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 4'b0001, "R4 "},
      '{4'h2, 1'b1, 32'hF0F0F0F0, 32'h0FF00FF0, 32'h00F000F0, 4'b0000, "R5 "},
      '{4'h2, 1'b0, 32'hF0F0F0F0, 32'h0FF00FF0, 32'h00F000F0, 4'b0000, "R5 "},
      '{4'h3, 1'b1, 32'hF0F0F0F0, 32'h0FF00FF0, 32'hFFF0FFF0, 4'b0000, "R5 "},
      '{4'h3, 1'b0, 32'hF0F0F0F0, 32'h0FF00FF0, 32'hFFF0FFF0, 4'b0000, "R5 "},
      '{4'hB, 1'b1, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 4'b0000, "R6 "},
      '{4'hB, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'b0000, "R6 "},
      '{4'hB, 1'b1, 32'h80000000, 32'h7FFFFFFF, 32'h00000001, 4'b0000, "R6 "},
      '{4'hB, 1'b1, 32'h00000005, 32'h00000005, 32'h00000000, 4'b0000, "R6 "},
      '{4'hE, 1'b1, 32'hFFFFFFFE, 32'h00000003, 32'hFFFFFFFA, 4'b0000, "R7 "},
      '{4'hE, 1'b0, 32'h0000FFFF, 32'h0000FFFF, 32'hFFFE0001, 4'b0000, "R7 "},
      '{4'hE, 1'b0, 32'h00010000, 32'h00010000, 32'h00000000, 4'b0001, "R8 "},
      '{4'hE, 1'b1, 32'h00010000, 32'h00008000, 32'h80000000, 4'b0001, "R8 "},
      '{4'hE, 1'b1, 32'hFFFF0000, 32'h00008000, 32'h80000000, 4'b0000, "R8 "},
      '{4'hE, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 4'b0001, "R8 "}
   };

   logic        clk = 1'b0;
   logic [31:0] a, b;
   logic [3:0]  fn;
   logic        is_signed;
   logic [31:0] result;
   logic [3:0]  cond;
   int          n_chk = 0;
   int          n_bad = 0;
   logic        done = 1'b0;

   always #5 clk = ~clk;

   alu32_core #(.WIDTH(32)) u_alu32_core (
      .a(a), .b(b), .fn(fn), .is_signed(is_signed),
      .result(result), .cond(cond)
   );

   task automatic check(input string req, input logic [31:0] er, input logic [3:0] ec);
      n_chk++;
      if (result !== er || cond !== ec) begin
         n_bad++;
         $display("FAIL %s: fn=%h sg=%b a=%h b=%h got r=%h cc=%b expected r=%h cc=%b",
                  req, fn, is_signed, a, b, result, cond, er, ec);
      end
   endtask

   task automatic drive(input logic [3:0] f, input logic s, input logic [31:0] x, input logic [31:0] y);
      @(negedge clk);
      fn = f; is_signed = s; a = x; b = y;
      #1;
   endtask

   initial begin
      a = '0; b = '0; fn = 4'h0; is_signed = 1'b0;
      #2;
      check("R1 idle", 32'h0, 4'b0000);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].fn, VEC[i].sg, VEC[i].a, VEC[i].b);
         check(string'(VEC[i].tag), VEC[i].r, VEC[i].cc);
      end

      // R6 vs R3: the same extreme pair overflows under subtract only
      drive(4'h1, 1'b1, 32'h80000000, 32'h7FFFFFFF);
      check("R3 sub-extreme", 32'h00000001, 4'b0001);

      // R9: each unused code with all-ones operands in both modes
      for (int c = 0; c < 16; c++) begin
         if (c inside {4, 5, 6, 7, 8, 9, 10, 12, 13, 15}) begin
            for (int s = 0; s < 2; s++) begin
               drive(4'(c), 1'(s), 32'hFFFFFFFF, 32'hFFFFFFFF);
               check("R9", 32'h0, 4'b0000);
            end
         end
      end

      // R10: outputs follow each input without a clock edge
      drive(4'h0, 1'b0, 32'h00000001, 32'h00000002);
      check("R10 base", 32'h00000003, 4'b0000);
      #1 a = 32'h00000010; #1;
      check("R10 a", 32'h00000012, 4'b0000);
      #1 b = 32'hFFFFFFFF; #1;
      check("R10 b", 32'h0000000F, 4'b0001);
      #1 is_signed = 1'b1; #1;
      check("R10 sg", 32'h0000000F, 4'b0000);
      #1 fn = 4'h3; #1;
      check("R10 fn", 32'hFFFFFFFF, 4'b0000);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule